// File: doc/BRIEF.md
# Forwarded-Clock Serial Byte Transmitter

This block sends bytes across a short board-level link to a neighbouring chip. A byte is handed over on a valid/ready input and held until the far side raises its ready line. The transmitter then raises an enable line and runs a forwarded clock at half the system clock rate. It shifts the byte out on one or two data wires, most significant bits first. The data wires change together with the rising edge of the forwarded clock, so the receiver can sample them on the falling edge.

After the last bit the enable line drops, and the receiver's ready line is checked again before any further byte leaves. Each byte therefore needs its own ready check. The lane count is a parameter: one lane takes eight forwarded-clock periods per byte and two lanes take four. The block does not interpret frame contents and leaves pad and buffer details to the pin level.

Top module: `fwdclk_byte_tx`

## Requirements
- R1: A byte starts only after it has been accepted and `rx_rdy` was sampled high while the byte was waiting. `tx_en` rises at the first clock edge where that holds, and stays low for as long as `rx_rdy` is low.
- R2: For each byte, `tx_en` stays high for exactly 2*(DATA_W/LANES) consecutive system cycles and then stays low for at least one cycle. The next byte needs a fresh `rx_rdy` check.
- R3: While `tx_en` is high, `tx_clk` is high in the first cycle of every two-cycle bit period and low in the second. `tx_clk` is low whenever `tx_en` is low.
- R4: `tx_dat` changes only in a cycle where `tx_clk` goes from low to high. It holds its value through the low half of `tx_clk` and is zero whenever `tx_en` is low.
- R5: Bits leave most significant first. With two lanes, each beat carries the next two bits, and `tx_dat[1]` holds the more significant one of the pair.
- R6: `in_ready` is high only while the transmitter holds no byte. A byte is taken at a clock edge where `in_valid` and `in_ready` are both high.
- R7: With LANES=1 a byte takes 8 beats (16 system cycles of `tx_en`). With LANES=2 it takes 4 beats (8 cycles).
- R8: While `rst_n` is low, `tx_en`, `tx_clk` and `tx_dat` are zero and `in_ready` is high. This holds even when reset arrives in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Transmitter is empty and can take a byte |
| rx_rdy | input | 1 | Far-side receiver can take a byte |
| tx_en | output | 1 | Transfer in progress |
| tx_clk | output | 1 | Forwarded clock, half the system rate, low while idle |
| tx_dat | output | LANES | Serial data, most significant bits first |

## Verification
Both lane widths run side by side against a behavioural model. The byte values include alternating patterns (0xA5, 0x5A, 0xC3), single-bit values (0x80, 0x01) and all-zero and all-ones bytes. Together these catch a reversed bit order, swapped lanes and a stuck wire. Back-to-back traffic with `rx_rdy` held high shows that the idle gap and the ready re-check happen on every byte. A byte parked while `rx_rdy` is low separates gating by readiness from gating by input validity. A random `rx_rdy` phase and a reset in the middle of a byte cover restart from any state. A receiver in the bench samples on falling `tx_clk`, rebuilds each byte and compares it with the accepted one.

// File: rtl/fwdclk_byte_tx_pkg.sv
package fwdclk_byte_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_SEND = 2'd2
   } fbt_state_e;
endpackage

// File: rtl/fwdclk_byte_tx_seq.sv
// Sequencer: owns the byte state, the beat count and the forwarded clock phase.
module fwdclk_byte_tx_seq
   import fwdclk_byte_tx_pkg::*;
#(
   parameter int BEATS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic rx_rdy,
   output logic in_ready,
   output logic load,
   output logic first,
   output logic step,
   output logic done,
   output logic tx_en,
   output logic tx_clk
);
   localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);

   fbt_state_e    state_q;
   logic [CW-1:0] beat_q;
   logic          en_q;
   logic          clk_q;
   logic          last;

   always_comb begin
      last     = (beat_q == LAST_BEAT);
      in_ready = (state_q == ST_IDLE);
      load     = (state_q == ST_IDLE) && in_valid;
      first    = (state_q == ST_HOLD) && rx_rdy;
      step     = (state_q == ST_SEND) && !clk_q && !last;
      done     = (state_q == ST_SEND) && !clk_q && last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         en_q    <= 1'b0;
         clk_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (load) state_q <= ST_HOLD;
            end
            ST_HOLD: begin
               if (first) begin
                  state_q <= ST_SEND;
                  en_q    <= 1'b1;
                  clk_q   <= 1'b1;
                  beat_q  <= '0;
               end
            end
            ST_SEND: begin
               if (clk_q) begin
                  clk_q <= 1'b0;
               end else if (last) begin
                  state_q <= ST_IDLE;
                  en_q    <= 1'b0;
               end else begin
                  clk_q  <= 1'b1;
                  beat_q <= beat_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tx_en  = en_q;
   assign tx_clk = clk_q;
endmodule

// File: rtl/fwdclk_byte_tx_shreg.sv
// Shift register: holds the accepted byte and drives the data lanes.
module fwdclk_byte_tx_shreg #(
   parameter int DATA_W = 8,
   parameter int LANES  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              first,
   input  logic              step,
   input  logic              done,
   output logic [LANES-1:0]  dout
);
   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] hold_nx;
   logic [LANES-1:0]  head;
   logic [LANES-1:0]  dout_q;

   generate
      if (LANES == 1) begin : g_single
         assign head    = hold_q[DATA_W-1];
         assign hold_nx = {hold_q[DATA_W-2:0], 1'b0};
      end else begin : g_multi
         assign head    = hold_q[DATA_W-1 -: LANES];
         assign hold_nx = {hold_q[DATA_W-LANES-1:0], {LANES{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         dout_q <= '0;
      end else begin
         if (load) begin
            hold_q <= din;
         end else if (first || step) begin
            hold_q <= hold_nx;
            dout_q <= head;
         end else if (done) begin
            dout_q <= '0;
         end
      end
   end

   assign dout = dout_q;
endmodule

// File: rtl/fwdclk_byte_tx.sv
module fwdclk_byte_tx #(
   parameter int DATA_W = 8,
   parameter int LANES  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              rx_rdy,
   output logic              tx_en,
   output logic              tx_clk,
   output logic [LANES-1:0]  tx_dat
);
   localparam int BEATS = DATA_W / LANES;

   generate
      if (!(LANES == 1 || LANES == 2)) begin : g_bad_lanes
         $error("fwdclk_byte_tx: LANES must be 1 or 2");
      end
      if ((DATA_W % LANES) != 0 || DATA_W < 2) begin : g_bad_width
         $error("fwdclk_byte_tx: DATA_W must be a multiple of LANES and at least 2");
      end
   endgenerate

   logic load, first, step, done;

   fwdclk_byte_tx_seq #(.BEATS(BEATS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .rx_rdy   (rx_rdy),
      .in_ready (in_ready),
      .load     (load),
      .first    (first),
      .step     (step),
      .done     (done),
      .tx_en    (tx_en),
      .tx_clk   (tx_clk)
   );

   fwdclk_byte_tx_shreg #(.DATA_W(DATA_W), .LANES(LANES)) u_shreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .din   (in_data),
      .first (first),
      .step  (step),
      .done  (done),
      .dout  (tx_dat)
   );
endmodule

// File: rtl/fwdclk_byte_tx_chk.sv
module fwdclk_byte_tx_chk #(
   parameter int DATA_W = 8,
   parameter int LANES  = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             rx_rdy,
   input logic             tx_en,
   input logic             tx_clk,
   input logic [LANES-1:0] tx_dat
);
   localparam int BEATS = DATA_W / LANES;
   localparam int RUN   = 2 * BEATS;
   localparam int RW    = $clog2(RUN + 2);

   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= '0;
      else if (tx_en) run_q <= run_q + 1'b1;
      else            run_q <= '0;
   end

   AST_START_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> $past(rx_rdy)); // R1
   AST_GAP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |=> !tx_en); // R2
   AST_EN_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> (run_q == RW'(RUN))); // R7
   AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_clk); // R3
   AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en)) |-> (tx_clk != $past(tx_clk))); // R3
   AST_DAT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (tx_dat == '0)); // R4
   AST_DAT_HELD_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !tx_clk && $past(tx_en)) |-> $stable(tx_dat)); // R4
   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !tx_en); // R6
endmodule

bind fwdclk_byte_tx fwdclk_byte_tx_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_ready (in_ready),
   .rx_rdy   (rx_rdy),
   .tx_en    (tx_en),
   .tx_clk   (tx_clk),
   .tx_dat   (tx_dat)
);

// File: tb/fwdclk_byte_tx_bench.sv
module fwdclk_byte_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          rst_n = 1'b0;
   logic          rx_rdy = 1'b0;
   logic          v [2];
   logic [DW-1:0] dt [2];
   logic          rdy [2];
   logic          en [2];
   logic          tck [2];
   logic [1:0]    dat [2];
   logic [0:0]    dat1;
   logic [1:0]    dat2;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   fwdclk_byte_tx #(.DATA_W(DW), .LANES(1)) u_fwdclk_byte_tx (
      .clk(clk), .rst_n(rst_n), .in_valid(v[0]), .in_data(dt[0]), .in_ready(rdy[0]),
      .rx_rdy(rx_rdy), .tx_en(en[0]), .tx_clk(tck[0]), .tx_dat(dat1));
   fwdclk_byte_tx #(.DATA_W(DW), .LANES(2)) u_fwdclk_byte_tx_w2 (
      .clk(clk), .rst_n(rst_n), .in_valid(v[1]), .in_data(dt[1]), .in_ready(rdy[1]),
      .rx_rdy(rx_rdy), .tx_en(en[1]), .tx_clk(tck[1]), .tx_dat(dat2));
   assign dat[0] = {1'b0, dat1};
   assign dat[1] = dat2;

   // behavioural reference: mode 0 empty, 1 waiting, 2 sending (half-period count)
   int            m_mode [2];
   int            m_half [2];
   logic [DW-1:0] m_byte [2];
   logic [DW-1:0] sent_q0 [$];
   logic [DW-1:0] sent_q1 [$];

   always @(posedge clk or negedge rst_n) begin
      for (int d = 0; d < 2; d++) begin
         int beats;
         beats = DW / (d + 1);
         if (!rst_n) begin
            m_mode[d] = 0; m_half[d] = 0;
         end else if (m_mode[d] == 0) begin
            if (v[d]) begin
               m_byte[d] = dt[d]; m_mode[d] = 1;
               if (d == 0) sent_q0.push_back(dt[d]); else sent_q1.push_back(dt[d]);
            end
         end else if (m_mode[d] == 1) begin
            if (rx_rdy) begin m_mode[d] = 2; m_half[d] = 0; end
         end else begin
            m_half[d] = m_half[d] + 1;
            if (m_half[d] == 2 * beats) m_mode[d] = 0;
         end
      end
      if (!rst_n) begin sent_q0.delete(); sent_q1.delete(); end
   end

   task automatic check(input string req, input string what, input int d, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s lanes=%0d %s actual=%0h expected=%0h t=%0t", req, d + 1, what, act, exp, $time);
      end
   endtask

   // receiver model: samples on falling tx_clk, rebuilds bytes
   logic [DW-1:0] rx_sh [2];
   int            rx_n  [2];
   logic          tck_prev [2];

   always @(negedge clk) begin
      for (int d = 0; d < 2; d++) begin
         int lanes, beats, b, e_en, e_clk, e_dat;
         lanes = d + 1;
         beats = DW / lanes;
         e_en  = (m_mode[d] == 2);
         e_clk = e_en && (m_half[d] % 2 == 0);
         b     = m_half[d] / 2;
         e_dat = e_en ? ((m_byte[d] >> (DW - lanes * (b + 1))) & ((1 << lanes) - 1)) : 0;
         if (!rst_n) begin
            check("R8", "tx_en", d, en[d], 0);
            check("R8", "tx_clk", d, tck[d], 0);
            check("R8", "tx_dat", d, dat[d], 0);
            check("R8", "in_ready", d, rdy[d], 1);
            rx_n[d] = 0; tck_prev[d] = 0;
         end else begin
            check("R1 R2 R7", "tx_en", d, en[d], e_en);
            check("R3", "tx_clk", d, tck[d], e_clk);
            check("R4 R5", "tx_dat", d, dat[d], e_dat);
            check("R6", "in_ready", d, rdy[d], (m_mode[d] == 0));
            if (tck_prev[d] && !tck[d]) begin
               rx_sh[d] = (rx_sh[d] << lanes) | DW'(dat[d]);
               rx_n[d]  = rx_n[d] + 1;
               if (rx_n[d] == beats) begin
                  logic [DW-1:0] exp_b;
                  rx_n[d] = 0;
                  if (d == 0 && sent_q0.size() > 0) exp_b = sent_q0.pop_front();
                  else if (d == 1 && sent_q1.size() > 0) exp_b = sent_q1.pop_front();
                  else exp_b = 'x;
                  check("R5", "rebuilt byte", d, rx_sh[d], exp_b);
               end
            end
            tck_prev[d] = tck[d];
         end
      end
   end

   task automatic send(input int d, input logic [DW-1:0] b);
      bit was_rdy;
      @(negedge clk);
      v[d] = 1'b1; dt[d] = b;
      forever begin
         was_rdy = rdy[d];
         @(negedge clk);
         if (was_rdy) break;
      end
      v[d] = 1'b0;
   endtask

   task automatic send_list(input int d);
      logic [DW-1:0] pats [8] = '{8'hA5, 8'h80, 8'h01, 8'hFF, 8'h00, 8'h3C, 8'h5A, 8'hC3};
      foreach (pats[i]) send(d, pats[i]);
   endtask

   task automatic send_rand(input int d, input int n);
      for (int i = 0; i < n; i++) send(d, DW'($urandom));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      v[0] = 0; v[1] = 0; dt[0] = '0; dt[1] = '0;
      idle(3);
      #1 rst_n = 1'b1;
      // back-to-back patterns with receiver always ready (R2 R5 R7)
      rx_rdy = 1'b1;
      fork
         send_list(0);
         send_list(1);
      join
      idle(40);
      // byte parked while receiver not ready (R1)
      rx_rdy = 1'b0;
      fork
         send(0, 8'h96);
         send(1, 8'h69);
      join
      idle(30);
      rx_rdy = 1'b1;
      idle(40);
      // random receiver readiness
      fork
         send_rand(0, 20);
         send_rand(1, 20);
         begin
            for (int i = 0; i < 900; i++) begin
               @(negedge clk);
               rx_rdy = $urandom_range(0, 1) == 1;
            end
            rx_rdy = 1'b1;
         end
      join
      idle(40);
      // reset in the middle of a byte (R8)
      fork
         send(0, 8'hE7);
         send(1, 8'hE7);
      join
      idle(5);
      #1 rst_n = 1'b0;
      idle(3);
      #1 rst_n = 1'b1;
      fork
         send(0, 8'h4B);
         send(1, 8'hB4);
      join
      idle(40);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule